// File: doc/BRIEF.md
# Compare-Match Timer/Counter

This block is an up-counting timer/counter driven by a count-enable pulse from an external prescaler. A mode input selects how the counter runs. In free-running operation it wraps from its all-ones value back to zero. In clear-on-match operation it returns to zero on the tick after it reaches a programmed compare value, so that value sets the top of the count. Software can load the counter at any time through a write port.

Every enabled tick compares the current count with the compare register. A match raises a sticky match flag. The same match then acts on a waveform output pin, as picked by a two-bit action field. The pin can hold, toggle, clear or set. A sticky overflow flag records each wrap from all-ones to zero. Each flag is cleared by its own acknowledge input, and a new set in the same cycle wins over that acknowledge. Interrupt logic, prescaler generation and the PWM modes sit outside this block.

Top module: `cmp_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the count to 0, both flags to 0 and the waveform pin to 0.
- R2: In free-running mode (`modeSel` = 0), each clock edge with `tickEn` high and `cntWrEn` low raises the count by one, modulo 256. There is no clear at the compare value.
- R3: An enabled tick that takes the count from 0xFF to 0x00 sets `ovfFlag` at that same edge.
- R4: `ovfFlag` holds its value until an edge with `ovfAck` high and no new overflow. An overflow in the same cycle as `ovfAck` leaves the flag set.
- R5: On an edge with `tickEn` low and `cntWrEn` low, the count and the waveform pin keep their values, and neither flag is set.
- R6: In clear-on-match mode (`modeSel` = 2), an enabled tick that finds the count equal to `cmpVal` loads the count with 0 instead of incrementing it.
- R7: An enabled tick that finds count equal to `cmpVal` sets `cmpFlag`. The flag holds until `cmpAck` is high, and a match in the same cycle as `cmpAck` wins.
- R8: With `actSel` = 1, each match inverts the waveform pin. In clear-on-match mode with compare value N, the pin period is 2·(N+1) ticks.
- R9: On a match, `actSel` = 2 drives the pin to 0, `actSel` = 3 drives it to 1, and `actSel` = 0 leaves it unchanged.
- R10: An edge with `cntWrEn` high loads `cntWrData` into the count, whether `tickEn` is high or not. In that cycle it takes priority over counting and suppresses any match: no `cmpFlag` set and no pin change.
- R11: Mode values other than 2 (1 and 3 to 7) count exactly as free-running mode.
- R12: `actSel` has no effect on the count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Count-enable pulse from the prescaler |
| modeSel | input | 3 | Counting mode: 2 = clear on match, anything else = free-running |
| actSel | input | 2 | Pin action on match: 0 hold, 1 toggle, 2 clear, 3 set |
| cmpVal | input | 8 | Compare value |
| cntWrEn | input | 1 | Software load strobe for the counter |
| cntWrData | input | 8 | Value to load into the counter |
| ovfAck | input | 1 | Clears the overflow flag |
| cmpAck | input | 1 | Clears the match flag |
| count | output | 8 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare-match flag |
| wavePin | output | 1 | Waveform output pin |

## Verification
The bench targets several corner cases, each tied to a specific failure:
- A load in the same cycle where count equals the compare value, with a pin action armed. A design that let the match through would raise the match flag or move the pin.
- Acknowledges that arrive in the same cycle as a new overflow or a new match. A design where the clear wins would drop an event.
- A compare value of 0 in clear-on-match mode, where the counter must sit at zero and still match on every tick.
- An unsupported mode value, which must count past the compare value.
- Toggle-period runs that compare the count sequence under different action values. These catch an off-by-one in the clear or a count sequence that depends on the action field.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;

  localparam logic [MODE_W-1:0] MODE_CLR_ON_MATCH = 3'd2;

  typedef enum logic [ACT_W-1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pinAct_e;

  // strobes from control to datapath, valid for one clock edge
  typedef struct packed {
    logic    load;
    logic    inc;
    logic    clear;
    logic    setOvf;
    logic    setCmp;
    pinAct_e pinOp;
  } tmrStrobe_t;

endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
(
  input  logic              tickEn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ACT_W-1:0]  actSel,
  input  logic              cntWrEn,
  input  logic              atMatch,
  input  logic              atMax,
  output tmrStrobe_t        strobe
);

  logic clrMode;

  always_comb begin
    clrMode = (modeSel == MODE_CLR_ON_MATCH);
    strobe  = '0;
    if (cntWrEn) begin
      // software load wins over counting and masks any match
      strobe.load = 1'b1;
    end else if (tickEn) begin
      if (clrMode && atMatch) begin
        strobe.clear = 1'b1;
      end else begin
        strobe.inc = 1'b1;
      end
      strobe.setOvf = atMax;
      if (atMatch) begin
        strobe.setCmp = 1'b1;
        strobe.pinOp  = pinAct_e'(actSel);
      end
    end
  end

endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             ovfAck,
  input  logic             cmpAck,
  output logic             atMatch,
  output logic             atMax,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             wavePin
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign atMatch = (count == cmpVal);
  assign atMax   = &count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= cntWrData;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.inc) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovfFlag <= 1'b0;
    end else if (strobe.setOvf) begin
      ovfFlag <= 1'b1;
    end else if (ovfAck) begin
      ovfFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpFlag <= 1'b0;
    end else if (strobe.setCmp) begin
      cmpFlag <= 1'b1;
    end else if (cmpAck) begin
      cmpFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wavePin <= 1'b0;
    end else begin
      case (strobe.pinOp)
        PIN_TOGGLE: wavePin <= ~wavePin;
        PIN_CLEAR:  wavePin <= 1'b0;
        PIN_SET:    wavePin <= 1'b1;
        default:    wavePin <= wavePin;
      endcase
    end
  end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ACT_W-1:0]  actSel,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              cntWrEn,
  input  logic [CNT_W-1:0]  cntWrData,
  input  logic              ovfAck,
  input  logic              cmpAck,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              cmpFlag,
  output logic              wavePin
);

  tmrStrobe_t strobe;
  logic       atMatch;
  logic       atMax;

  cmp_timer_ctrl ctrl_i (
    .tickEn  (tickEn),
    .modeSel (modeSel),
    .actSel  (actSel),
    .cntWrEn (cntWrEn),
    .atMatch (atMatch),
    .atMax   (atMax),
    .strobe  (strobe)
  );

  cmp_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cmpVal    (cmpVal),
    .cntWrData (cntWrData),
    .ovfAck    (ovfAck),
    .cmpAck    (cmpAck),
    .atMatch   (atMatch),
    .atMax     (atMax),
    .count     (count),
    .ovfFlag   (ovfFlag),
    .cmpFlag   (cmpFlag),
    .wavePin   (wavePin)
  );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tickEn,
  input logic [MODE_W-1:0] modeSel,
  input logic [ACT_W-1:0]  actSel,
  input logic [CNT_W-1:0]  cmpVal,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData,
  input logic              ovfAck,
  input logic              cmpAck,
  input logic [CNT_W-1:0]  count,
  input logic              ovfFlag,
  input logic              cmpFlag,
  input logic              wavePin
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic tick;
  assign tick = tickEn && !cntWrEn;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == '0) && !ovfFlag && !cmpFlag && !wavePin);

  // R2, R11: every mode except clear-on-match increments
  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    tick && (modeSel != MODE_CLR_ON_MATCH) |=> count == $past(count) + ONE);

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    tick && (count == ALL_ONES) |=> ovfFlag);

  p_ovf_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ovfFlag && !ovfAck |=> ovfFlag);

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !tickEn && !cntWrEn |=> $stable(count) && $stable(wavePin));

  p_ctc_clear_r6: assert property (@(posedge clk) disable iff (rst)
    tick && (modeSel == MODE_CLR_ON_MATCH) && (count == cmpVal) |=> count == '0);

  p_cmp_set_r7: assert property (@(posedge clk) disable iff (rst)
    tick && (count == cmpVal) |=> cmpFlag);

  p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    tick && (count == cmpVal) && (actSel == 2'd1) |=> wavePin != $past(wavePin));

  p_set_r9: assert property (@(posedge clk) disable iff (rst)
    tick && (count == cmpVal) && (actSel == 2'd3) |=> wavePin);

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    cntWrEn |=> (count == $past(cntWrData)) && $stable(wavePin));

endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tickEn    (tickEn),
  .modeSel   (modeSel),
  .actSel    (actSel),
  .cmpVal    (cmpVal),
  .cntWrEn   (cntWrEn),
  .cntWrData (cntWrData),
  .ovfAck    (ovfAck),
  .cmpAck    (cmpAck),
  .count     (count),
  .ovfFlag   (ovfFlag),
  .cmpFlag   (cmpFlag),
  .wavePin   (wavePin)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic [2:0] modeSel = '0;
  logic [1:0] actSel = '0;
  logic [7:0] cmpVal = '0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       ovfAck = 1'b0;
  logic       cmpAck = 1'b0;
  logic [7:0] count;
  logic       ovfFlag;
  logic       cmpFlag;
  logic       wavePin;

  int errCnt = 0;
  int chkCnt = 0;

  always #5 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .modeSel(modeSel), .actSel(actSel),
    .cmpVal(cmpVal), .cntWrEn(cntWrEn), .cntWrData(cntWrData), .ovfAck(ovfAck),
    .cmpAck(cmpAck), .count(count), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
    .wavePin(wavePin)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       tick;
    logic [2:0] mode;
    logic [1:0] act;
    logic [7:0] cmp;
    logic       oAck;
    logic       cAck;
    logic [7:0] eCnt;
    logic       eOvf;
    logic       eCmp;
    logic       ePin;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 17;
  //                 wr  wd     tk  mode  act  cmp   oA  cA   eCnt   eO  eC  eP  req
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'hFD, 1'b0, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'hFD, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 load
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 wrap
    '{1'b0, 8'h00, 1'b0, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 idle
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd0, 8'h10, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 sticky
    '{1'b0, 8'h00, 1'b0, 3'd0, 2'd0, 8'h10, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 ack
    '{1'b1, 8'h05, 1'b1, 3'd0, 2'd3, 8'h01, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 masks match
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd3, 8'h05, 1'b0, 1'b0, 8'h06, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 set, R7
    '{1'b0, 8'h00, 1'b0, 3'd0, 2'd3, 8'h05, 1'b0, 1'b1, 8'h06, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 ack
    '{1'b0, 8'h00, 1'b1, 3'd2, 2'd2, 8'h07, 1'b0, 1'b0, 8'h07, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 approach
    '{1'b0, 8'h00, 1'b1, 3'd2, 2'd2, 8'h07, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 clear, R9 clear
    '{1'b0, 8'h00, 1'b1, 3'd2, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 set wins, R9 hold
    '{1'b0, 8'h00, 1'b1, 3'd5, 2'd1, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1, 1'b1, 4'd11}, // R11, R8 toggle
    '{1'b0, 8'h00, 1'b1, 3'd5, 2'd1, 8'h00, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1, 1'b1, 4'd11}, // R11 passes cmp
    '{1'b1, 8'hFF, 1'b0, 3'd0, 2'd0, 8'h80, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd10}, // R10
    '{1'b0, 8'h00, 1'b1, 3'd0, 2'd0, 8'h80, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd4}   // R4 set wins
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [7:0] eCnt,
                          input logic eOvf, input logic eCmp, input logic ePin);
    check({tag, " count"}, count, eCnt);
    check({tag, " ovfFlag"}, {7'd0, ovfFlag}, {7'd0, eOvf});
    check({tag, " cmpFlag"}, {7'd0, cmpFlag}, {7'd0, eCmp});
    check({tag, " wavePin"}, {7'd0, wavePin}, {7'd0, ePin});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; tickEn = 1'b0; cntWrEn = 1'b0; ovfAck = 1'b0; cmpAck = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    checkAll("R1 reset", 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 power-up reset", 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cntWrEn = VECS[i].wr;   cntWrData = VECS[i].wd;
      tickEn  = VECS[i].tick; modeSel   = VECS[i].mode;
      actSel  = VECS[i].act;  cmpVal    = VECS[i].cmp;
      ovfAck  = VECS[i].oAck; cmpAck    = VECS[i].cAck;
      @(posedge clk);
      #1;
      checkAll($sformatf("R%0d vec%0d", VECS[i].req, i),
               VECS[i].eCnt, VECS[i].eOvf, VECS[i].eCmp, VECS[i].ePin);
      @(negedge clk);
    end

    // R8 toggle period 2*(N+1) with N=3; R12 same count sequence under clear action
    for (int a = 1; a <= 2; a++) begin
      doReset();
      modeSel = 3'd2; actSel = 2'(a); cmpVal = 8'd3; tickEn = 1'b1;
      for (int k = 1; k <= 16; k++) begin
        @(posedge clk);
        #1;
        check($sformatf("R12 count act=%0d tick%0d", a, k), count, 8'(k % 4));
        check($sformatf("R8 pin act=%0d tick%0d", a, k), {7'd0, wavePin},
              (a == 1) ? 8'((k / 4) % 2) : 8'd0);
        @(negedge clk);
      end
    end

    // R1 reset in the middle of activity
    tickEn = 1'b1; modeSel = 3'd0; actSel = 2'd3; cmpVal = 8'd0;
    repeat (3) @(negedge clk);
    doReset();

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule